// File: doc/BRIEF.md
# Testable Decoded-Select Multiplexer

This block chooses one of several data words using an encoded select. An internal decoder turns the select into one enable line per input. In functional mode exactly one of those lines is high for every legal select. Around the decoder and the multiplexer sit test hooks that let stuck-at faults on each enable line be both provoked and observed.

The first hook is test gating: it can pull every enable low at once, which the decoder by itself never does. The second is a bus holder. When no enable is high, the output repeats the last value it drove, so a stuck-off enable shows up as a failure to overwrite old data. The third is a pull-up that works only in test mode and forces the output to all ones while the enables are forced off. The fourth is an observation path: it folds the enable lines through an XOR tree into a flop on the scan chain. A contention output reports when more than one enable is high, a state that only a faulty enable can produce.

Top module: `tmux_top`

## Requirements
- R1: With testMode low and selCode below NUM_IN, exactly one enable is high and dataOut equals input word selCode in the same cycle. Word k occupies bits [k*DATA_W +: DATA_W] of dataIn.
- R2: A selCode of NUM_IN or above drives no enable. dataOut then keeps the value it had in the previous cycle, unless the pull-up is active.
- R3: With testMode and forceOff both high, all enables are low whatever selCode is. With the pull-up off, dataOut keeps its previous value, so the stuck-off test is to select one input first and then select the opposite data on the target input.
- R4: forceOff has no effect when testMode is low.
- R5: pullUpActive is high only when testMode and pullUpReq are both high. When forceOff is also active, dataOut is all ones, and the holder keeps all ones afterwards. pullUpReq is ignored when testMode is low.
- R6: On a rising clk edge with scanEn low, the scan flop loads the XOR of all enable lines. That is 1 when one input is selected and 0 when none is. scanOut shows the flop.
- R7: On a rising clk edge with scanEn high, the scan flop loads scanIn.
- R8: contention is high exactly when more than one enable is high. In every reachable state it stays low.
- R9: While rstN is low, the scan flop and the holder are cleared asynchronously, so scanOut is 0 and an unselected output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holder and scan flop |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | NUM_IN*DATA_W | Packed input words, word 0 in the low bits |
| selCode | input | SEL_W | Encoded select |
| testMode | input | 1 | Enables the test hooks |
| forceOff | input | 1 | Requests all enables low (test mode only) |
| pullUpReq | input | 1 | Requests the output pull-up (test mode only) |
| scanEn | input | 1 | Scan shift when high, parity capture when low |
| scanIn | input | 1 | Serial scan input |
| dataOut | output | DATA_W | Multiplexed, held or pulled-up data |
| pullUpActive | output | 1 | Pull-up currently enabled |
| contention | output | 1 | More than one enable high |
| scanOut | output | 1 | Scan flop output |

## Verification
The hardest state to reach from the ports is the all-enables-off state followed by a fresh selection of opposite data. It is the only way to show that the holder really keeps old data and that a new enable really overwrites it. The stimulus first selects a word, then raises testMode and forceOff while pointing the select at a word with complementary bits, and checks that the old word persists. It then drops forceOff and checks that the complementary word appears. The parity captured in the scan flop is checked after each of these steps, and again after the pull-up drives the output to all ones.

// File: rtl/tmux_pkg.sv
package tmux_pkg;
  localparam int DEF_INPUTS = 4;
  localparam int DEF_WIDTH  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic gateOff;        // all enables forced low
    logic pullUp;         // output pull-up enabled
    logic captureParity;  // scan flop loads XOR tree
  } tmuxStrobe_t;
endpackage

// File: rtl/tmux_ctrl.sv
module tmux_ctrl
  import tmux_pkg::*;
#(
  parameter int NUM_IN = DEF_INPUTS,
  parameter int SEL_W  = $clog2(DEF_INPUTS) + 1
) (
  input  logic [SEL_W-1:0]  selCode,
  input  logic              testMode,
  input  logic              forceOff,
  input  logic              pullUpReq,
  input  logic              scanEn,
  output logic [NUM_IN-1:0] enVec,
  output tmuxStrobe_t       strobe
);
  logic [NUM_IN-1:0] decEn;

  always_comb begin
    strobe.gateOff       = testMode & forceOff;
    strobe.pullUp        = testMode & pullUpReq;
    strobe.captureParity = ~scanEn;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_dec
    assign decEn[i] = (selCode == SEL_W'(i));
    // NOR-style gate: low when decoder low or gating active
    assign enVec[i] = ~(~decEn[i] | strobe.gateOff);
  end
endmodule

// File: rtl/tmux_datapath.sv
module tmux_datapath
  import tmux_pkg::*;
#(
  parameter int NUM_IN = DEF_INPUTS,
  parameter int DATA_W = DEF_WIDTH
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN*DATA_W-1:0] dataIn,
  input  logic [NUM_IN-1:0]        enVec,
  input  tmuxStrobe_t              strobe,
  input  logic                     scanIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     contention,
  output logic                     scanOut
);
  localparam int CNT_W = $clog2(NUM_IN + 1);

  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] holdQ;
  logic [CNT_W-1:0]  enCount;
  logic              anyEn;
  logic              enParity;
  logic              scanQ;

  always_comb begin
    selData = '0;
    enCount = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      selData = selData | (dataIn[i*DATA_W +: DATA_W] & {DATA_W{enVec[i]}});
      enCount = enCount + CNT_W'(enVec[i]);
    end
  end

  assign anyEn      = |enVec;
  assign enParity   = ^enVec;
  assign contention = (enCount > CNT_W'(1));

  always_comb begin
    if (anyEn)              dataOut = selData;
    else if (strobe.pullUp) dataOut = '1;
    else                    dataOut = holdQ;
  end

  // bus holder follows whatever the output carries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdQ <= '0;
    else       holdQ <= dataOut;
  end

  // mux-D scan flop observing the enable parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     scanQ <= 1'b0;
    else if (strobe.captureParity) scanQ <= enParity;
    else                           scanQ <= scanIn;
  end

  assign scanOut = scanQ;
endmodule

// File: rtl/tmux_top.sv
module tmux_top
  import tmux_pkg::*;
#(
  parameter int NUM_IN = DEF_INPUTS,
  parameter int DATA_W = DEF_WIDTH,
  parameter int SEL_W  = $clog2(DEF_INPUTS) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN*DATA_W-1:0] dataIn,
  input  logic [SEL_W-1:0]         selCode,
  input  logic                     testMode,
  input  logic                     forceOff,
  input  logic                     pullUpReq,
  input  logic                     scanEn,
  input  logic                     scanIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     pullUpActive,
  output logic                     contention,
  output logic                     scanOut
);
  logic [NUM_IN-1:0] enVec;
  tmuxStrobe_t       strobe;

  tmux_ctrl #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) ctrl_i (
    .selCode(selCode), .testMode(testMode), .forceOff(forceOff),
    .pullUpReq(pullUpReq), .scanEn(scanEn), .enVec(enVec), .strobe(strobe)
  );

  tmux_datapath #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .enVec(enVec), .strobe(strobe),
    .scanIn(scanIn), .dataOut(dataOut), .contention(contention),
    .scanOut(scanOut)
  );

  assign pullUpActive = strobe.pullUp;
endmodule

// File: rtl/tmux_checks.sv
module tmux_checks #(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [SEL_W-1:0]  selCode,
  input logic              testMode,
  input logic              forceOff,
  input logic              pullUpReq,
  input logic              scanEn,
  input logic              scanIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              pullUpActive,
  input logic              contention,
  input logic              scanOut,
  input logic [NUM_IN-1:0] enVec
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_IN - 1);

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  p_one_hot_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && selCode <= LAST_SEL) |-> $countones(enVec) == 1);

  p_oor_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && selCode > LAST_SEL && !pullUpActive) |-> dataOut == $past(dataOut));

  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && forceOff) |-> enVec == '0);

  p_pullup_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    pullUpActive |-> (testMode && pullUpReq));

  p_pullup_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && forceOff && pullUpReq) |-> dataOut == '1);

  p_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> scanOut == $past(^enVec));

  p_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> scanOut == $past(scanIn));

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rstN)
    !contention && $onehot0(enVec));
endmodule

bind tmux_top tmux_checks #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .selCode(selCode), .testMode(testMode),
  .forceOff(forceOff), .pullUpReq(pullUpReq), .scanEn(scanEn), .scanIn(scanIn),
  .dataOut(dataOut), .pullUpActive(pullUpActive), .contention(contention),
  .scanOut(scanOut), .enVec(enVec)
);

// File: tb/tmux_top_tb_top.sv
`timescale 1ns/1ps
module tmux_top_tb_top;
  localparam int NUM_IN = 4;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IN*DATA_W-1:0] dataIn = {8'hC3, 8'h5A, 8'hA5, 8'h3C};
  logic [SEL_W-1:0] selCode = 3'd4;
  logic testMode = 1'b0, forceOff = 1'b0, pullUpReq = 1'b0;
  logic scanEn = 1'b0, scanIn = 1'b0;
  logic [DATA_W-1:0] dataOut;
  logic pullUpActive, contention, scanOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmux_top #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .selCode(selCode),
    .testMode(testMode), .forceOff(forceOff), .pullUpReq(pullUpReq),
    .scanEn(scanEn), .scanIn(scanIn), .dataOut(dataOut),
    .pullUpActive(pullUpActive), .contention(contention), .scanOut(scanOut)
  );

  // {testMode, forceOff, pullUpReq, selCode, expected dataOut, expected scan, expected pullUpActive}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'b000, 3'd0, 8'h3C, 1'b1, 1'b0},  // R1 word 0
    {3'b000, 3'd1, 8'hA5, 1'b1, 1'b0},  // R1 word 1
    {3'b000, 3'd2, 8'h5A, 1'b1, 1'b0},  // R1 word 2
    {3'b000, 3'd3, 8'hC3, 1'b1, 1'b0},  // R1 word 3
    {3'b000, 3'd5, 8'hC3, 1'b0, 1'b0},  // R2 out of range holds
    {3'b010, 3'd1, 8'hA5, 1'b1, 1'b0},  // R4 forceOff ignored
    {3'b110, 3'd2, 8'hA5, 1'b0, 1'b0},  // R3 gated, old word held
    {3'b100, 3'd2, 8'h5A, 1'b1, 1'b0},  // R3 opposite data overwrites
    {3'b111, 3'd0, 8'hFF, 1'b0, 1'b1},  // R5 pull-up gives ones
    {3'b110, 3'd0, 8'hFF, 1'b0, 1'b0},  // R5 holder keeps ones
    {3'b001, 3'd7, 8'hFF, 1'b0, 1'b0},  // R5 pullUpReq ignored, R2 hold
    {3'b000, 3'd0, 8'h3C, 1'b1, 1'b0}   // R1 back to word 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    @(negedge clk);
    #1;
    check("R9 dataOut in reset", 32'(dataOut), 32'h0);
    check("R9 scanOut in reset", 32'(scanOut), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 dataOut after reset", 32'(dataOut), 32'h0);
    check("R2 scan parity none selected", 32'(scanOut), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      {testMode, forceOff, pullUpReq, selCode} = VEC[v][15:10];
      #2;
      check($sformatf("R1-table dataOut vec %0d", v), 32'(dataOut), 32'(VEC[v][9:2]));
      check($sformatf("R5 pullUpActive vec %0d", v), 32'(pullUpActive), 32'(VEC[v][0]));
      check($sformatf("R8 contention vec %0d", v), 32'(contention), 32'h0);
      @(negedge clk);
      check($sformatf("R6 scan parity vec %0d", v), 32'(scanOut), 32'(VEC[v][1]));
    end

    // R7: scan shift overrides capture
    selCode = 3'd1;
    testMode = 1'b0;
    forceOff = 1'b0;
    pullUpReq = 1'b0;
    scanEn = 1'b1;
    for (int b = 0; b < 4; b++) begin
      scanIn = (b == 1) ? 1'b0 : 1'b1;
      @(negedge clk);
      check($sformatf("R7 shift bit %0d", b), 32'(scanOut), 32'(scanIn));
    end
    scanEn = 1'b0;
    selCode = 3'd6;
    @(negedge clk);
    check("R6 capture after shift, none selected", 32'(scanOut), 32'h0);
    check("R2 hold after shift", 32'(dataOut), 32'hA5);

    // R9: asynchronous reset mid-run
    #2 rstN = 1'b0;
    #1;
    check("R9 async clear scanOut", 32'(scanOut), 32'h0);
    check("R9 async clear holder", 32'(dataOut), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule